// File: doc/BRIEF.md
# Serial Write-Only Control Register Port

This block is the slave end of a three-wire control link made of a select line, a serial clock and a serial data line. It oversamples all three pins with the system clock and shifts in frames while select is low. Each frame is 16 bits long and carries a chip code, a direction bit, a register address and a data byte. The frame is committed to a five-entry file of 8-bit control registers at the moment select returns high, and only if the frame is complete and well formed.

The register contents leave the block as decoded control fields: clocking and serial-format settings, power and timing-reset controls, zero-detect settings, filter and de-emphasis choices, soft mute, zero-flag polarity and one attenuation byte per channel. A power-down input holds every register at its default value and blocks writes. A master-clock-present input blocks writes without touching the stored values. Nothing can be read back through the link.

Top module: `serctl_regport`

## Requirements
- R1: A frame is 16 bits, sent most significant bit first and taken on rising edges of `sclk_i` while `csn_i` is low: frame bits 15:14 are the chip code, bit 13 the direction bit, bits 12:8 the register address and bits 7:0 the data. A frame with chip code 01, direction bit 1 and address 0 to 4 stores its data in the addressed register.
- R2: The register outputs keep their previous values while a frame is still being shifted in; a write appears only after `csn_i` goes high.
- R3: A frame whose chip code is not 01 or whose direction bit is 0 leaves every register unchanged.
- R4: A frame with fewer or more than 16 rising `sclk_i` edges before `csn_i` rises leaves every register unchanged.
- R5: A frame addressed to 5 through 31 leaves every register unchanged.
- R6: While `pdn_n` is low, the registers hold their defaults (register 0 = 0x8B, 1 = 0x02, 2 = 0x00, 3 and 4 = 0xFF) and frames have no effect.
- R7: While `mclk_ok` is low, frames have no effect and the registers keep their values.
- R8: Register 0 drives `auto_clk_en` (bit 7), `fmt_sel` (bits 4:2), `pwr_on` (bit 1) and `tim_run` (bit 0); register 1 drives, from bit 7 down to bit 0, `zdet_en`, `zdet_and`, `slow_roll`, `speed_sel[1:0]`, `deemph_sel[1:0]`, `soft_mute`; register 2 bit 2 drives `zflag_inv`; registers 3 and 4 drive `att_left` and `att_right`.
- R9: Writing 0 to the timing-reset bit changes no other register field.
- R10: After `rst_n` is released, every output shows the default register values of R6.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to oversample the link |
| rst_n | input | 1 | Asynchronous active-low reset to defaults |
| pdn_n | input | 1 | Active-low power-down: holds defaults and blocks writes |
| mclk_ok | input | 1 | High when the master clock is present; low blocks writes |
| csn_i | input | 1 | Active-low frame select |
| sclk_i | input | 1 | Serial clock, data taken on its rising edge |
| sdat_i | input | 1 | Serial data |
| auto_clk_en | output | 1 | Automatic clock-ratio detection enable |
| fmt_sel | output | 3 | Audio serial format select |
| pwr_on | output | 1 | Converter power control |
| tim_run | output | 1 | Timing reset control, 0 holds timing in reset |
| zdet_en | output | 1 | Zero-detect enable |
| zdet_and | output | 1 | Zero-detect combines both channels |
| slow_roll | output | 1 | Slow roll-off filter select |
| speed_sel | output | 2 | Sampling speed select |
| deemph_sel | output | 2 | De-emphasis select |
| soft_mute | output | 1 | Soft mute request |
| zflag_inv | output | 1 | Inverts zero-flag polarity |
| att_left | output | 8 | Left channel attenuation |
| att_right | output | 8 | Right channel attenuation |

## Verification
The commit decision and the write-blocking inputs meet in one cycle: the select rising edge can arrive while `pdn_n` is low or `mclk_ok` has just dropped. The bench flips both blocking inputs at random between frames of random address, length and header, and also completes frames while power-down is held, so the commit edge lands on a blocked cycle. A reference model that applies the acceptance rule of R1 and R3 to R7 predicts every register, and after each frame the full decoded output set is compared with it.

// File: rtl/serctl_pkg.sv
package serctl_pkg;
  localparam int REG_W     = 8;
  localparam int NUM_REGS  = 5;
  localparam int ADDR_W    = 5;
  localparam int HDR_W     = 3;
  localparam int FRAME_W   = HDR_W + ADDR_W + REG_W;
  localparam logic [HDR_W-1:0] HDR_OK = 3'b011; // chip code 01, write bit 1

  // Power-down value of each register
  function automatic logic [REG_W-1:0] reg_default(input int idx);
    case (idx)
      0:       return 8'h8B;
      1:       return 8'h02;
      2:       return 8'h00;
      default: return 8'hFF;
    endcase
  endfunction

  // Bits that can hold a 1; the rest are forced to zero on write
  function automatic logic [REG_W-1:0] reg_mask(input int idx);
    case (idx)
      0:       return 8'h9F;
      2:       return 8'h04;
      default: return 8'hFF;
    endcase
  endfunction
endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
  parameter int N      = 3,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [N-1:0] async_i,
  output logic [N-1:0] sync_o
);
  logic [N-1:0] stg [STAGES];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stg[0] <= '1;
    else        stg[0] <= async_i;
  end

  for (genvar s = 1; s < STAGES; s++) begin : g_stage
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) stg[s] <= '1;
      else        stg[s] <= stg[s-1];
    end
  end

  assign sync_o = stg[STAGES-1];
endmodule

// File: rtl/serctl_shift.sv
module serctl_shift #(
  parameter int FRAME_W = 16,
  parameter int CNT_W   = $clog2(FRAME_W + 2)
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               clr,
  input  logic               bit_stb,
  input  logic               bit_val,
  output logic [FRAME_W-1:0] frame_o,
  output logic [CNT_W-1:0]   cnt_o
);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(FRAME_W + 1);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      frame_o <= '0;
      cnt_o   <= '0;
    end else if (clr) begin
      frame_o <= '0;
      cnt_o   <= '0;
    end else if (bit_stb) begin
      frame_o <= {frame_o[FRAME_W-2:0], bit_val};
      // saturate just past a full frame so overlong frames stay invalid
      cnt_o   <= (cnt_o == CNT_MAX) ? cnt_o : cnt_o + 1'b1;
    end
  end
endmodule

// File: rtl/serctl_regs.sv
module serctl_regs
  import serctl_pkg::*;
#(
  parameter int NREG   = NUM_REGS,
  parameter int DW     = REG_W,
  parameter int AW     = ADDR_W
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           pdn_n,
  input  logic           we,
  input  logic [AW-1:0]  waddr,
  input  logic [DW-1:0]  wdata,
  output logic [NREG*DW-1:0] img_o
);
  for (genvar g = 0; g < NREG; g++) begin : g_reg
    logic [DW-1:0] q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                           q <= reg_default(g);
      else if (!pdn_n)                      q <= reg_default(g);
      else if (we && waddr == AW'(g))       q <= wdata & reg_mask(g);
    end
    assign img_o[g*DW +: DW] = q;
  end
endmodule

// File: rtl/serctl_regport.sv
module serctl_regport
  import serctl_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       pdn_n,
  input  logic       mclk_ok,
  input  logic       csn_i,
  input  logic       sclk_i,
  input  logic       sdat_i,
  output logic       auto_clk_en,
  output logic [2:0] fmt_sel,
  output logic       pwr_on,
  output logic       tim_run,
  output logic       zdet_en,
  output logic       zdet_and,
  output logic       slow_roll,
  output logic [1:0] speed_sel,
  output logic [1:0] deemph_sel,
  output logic       soft_mute,
  output logic       zflag_inv,
  output logic [7:0] att_left,
  output logic [7:0] att_right
);
  localparam int CNT_W = $clog2(FRAME_W + 2);
  localparam int IMG_W = NUM_REGS * REG_W;

  // pin index: 0 serial clock, 1 select, 2 data
  logic [2:0] pin_s;
  logic [1:0] edge_q;
  logic       sclk_rise, csn_rise, csn_hi;

  serctl_sync #(.N(3), .STAGES(2)) u_sync (
    .clk(clk), .rst_n(rst_n),
    .async_i({sdat_i, csn_i, sclk_i}),
    .sync_o(pin_s)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) edge_q <= 2'b11;
    else        edge_q <= pin_s[1:0];
  end

  assign csn_hi    = pin_s[1];
  assign sclk_rise = pin_s[0] & ~edge_q[0] & ~csn_hi;
  assign csn_rise  = pin_s[1] & ~edge_q[1];

  logic [FRAME_W-1:0] frame;
  logic [CNT_W-1:0]   bit_cnt;

  serctl_shift #(.FRAME_W(FRAME_W), .CNT_W(CNT_W)) u_shift (
    .clk(clk), .rst_n(rst_n),
    .clr(csn_hi | ~pdn_n),
    .bit_stb(sclk_rise),
    .bit_val(pin_s[2]),
    .frame_o(frame),
    .cnt_o(bit_cnt)
  );

  // named frame events for the checker
  logic [ADDR_W-1:0] wr_addr;
  logic [REG_W-1:0]  wr_data;
  logic              hdr_good, len_good, addr_good, frame_ok, wr_commit;

  assign wr_addr   = frame[REG_W +: ADDR_W];
  assign wr_data   = frame[REG_W-1:0];
  assign hdr_good  = frame[FRAME_W-1 -: HDR_W] == HDR_OK;
  assign len_good  = bit_cnt == CNT_W'(FRAME_W);
  assign addr_good = wr_addr < ADDR_W'(NUM_REGS);
  assign frame_ok  = hdr_good & len_good & addr_good;
  assign wr_commit = csn_rise & frame_ok & pdn_n & mclk_ok;

  logic [IMG_W-1:0] img;

  serctl_regs #(.NREG(NUM_REGS), .DW(REG_W), .AW(ADDR_W)) u_regs (
    .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n),
    .we(wr_commit), .waddr(wr_addr), .wdata(wr_data),
    .img_o(img)
  );

  // field decode
  assign auto_clk_en = img[7];
  assign fmt_sel     = img[4:2];
  assign pwr_on      = img[1];
  assign tim_run     = img[0];
  assign zdet_en     = img[15];
  assign zdet_and    = img[14];
  assign slow_roll   = img[13];
  assign speed_sel   = img[12:11];
  assign deemph_sel  = img[10:9];
  assign soft_mute   = img[8];
  assign zflag_inv   = img[18];
  assign att_left    = img[31:24];
  assign att_right   = img[39:32];
endmodule

// File: rtl/serctl_regport_chk.sv
module serctl_regport_chk
  import serctl_pkg::*;
(
  input logic                       clk,
  input logic                       rst_n,
  input logic                       pdn_n,
  input logic                       mclk_ok,
  input logic                       csn_rise,
  input logic                       wr_commit,
  input logic [ADDR_W-1:0]          wr_addr,
  input logic [REG_W-1:0]           wr_data,
  input logic [NUM_REGS*REG_W-1:0]  img
);
  function automatic logic [NUM_REGS*REG_W-1:0] default_img();
    logic [NUM_REGS*REG_W-1:0] v;
    for (int i = 0; i < NUM_REGS; i++) v[i*REG_W +: REG_W] = reg_default(i);
    return v;
  endfunction

  function automatic logic [REG_W-1:0] pick(input logic [NUM_REGS*REG_W-1:0] v,
                                            input logic [ADDR_W-1:0] a);
    return v[int'(a)*REG_W +: REG_W];
  endfunction

  assert_commit_lands_R1: assert property (@(posedge clk) disable iff (!rst_n)
    wr_commit |=> pick(img, $past(wr_addr)) == ($past(wr_data) & reg_mask(int'($past(wr_addr)))));

  assert_change_needs_csn_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(img) |-> ($past(csn_rise) || !$past(pdn_n)));

  assert_pdn_defaults_R6: assert property (@(posedge clk) disable iff (!rst_n)
    !pdn_n |=> img == default_img());

  assert_mclk_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!mclk_ok && pdn_n) |=> $stable(img));
endmodule

bind serctl_regport serctl_regport_chk u_chk (
  .clk(clk), .rst_n(rst_n), .pdn_n(pdn_n), .mclk_ok(mclk_ok),
  .csn_rise(csn_rise), .wr_commit(wr_commit),
  .wr_addr(wr_addr), .wr_data(wr_data), .img(img)
);

// File: tb/serctl_regport_bench.sv
module serctl_regport_bench;
  logic clk = 1'b0;
  logic rst_n = 1'b0, pdn_n = 1'b1, mclk_ok = 1'b1;
  logic csn_i = 1'b1, sclk_i = 1'b0, sdat_i = 1'b0;
  logic       auto_clk_en, pwr_on, tim_run, zdet_en, zdet_and, slow_roll, soft_mute, zflag_inv;
  logic [2:0] fmt_sel;
  logic [1:0] speed_sel, deemph_sel;
  logic [7:0] att_left, att_right;

  int checks = 0, failures = 0;
  bit done = 0;
  logic [7:0] m [5];

  always #5 clk = ~clk;

  serctl_regport u_serctl_regport (.*);

  function automatic logic [7:0] dflt(input int i);
    logic [7:0] t [5] = '{8'h8B, 8'h02, 8'h00, 8'hFF, 8'hFF};
    return t[i];
  endfunction

  function automatic logic [7:0] keep(input int i);
    logic [7:0] t [5] = '{8'h9F, 8'hFF, 8'h04, 8'hFF, 8'hFF};
    return t[i];
  endfunction

  // reassemble register bytes from the decoded ports, layout per R8
  function automatic logic [39:0] seen();
    return {att_right, att_left,
            {5'b0, zflag_inv, 2'b0},
            {zdet_en, zdet_and, slow_roll, speed_sel, deemph_sel, soft_mute},
            {auto_clk_en, 2'b0, fmt_sel, pwr_on, tim_run}};
  endfunction

  function automatic logic [39:0] model();
    return {m[4], m[3], m[2], m[1], m[0]};
  endfunction

  function automatic bit accepted(input logic [15:0] f, input int n);
    return n == 16 && f[15:14] == 2'b01 && f[13] && f[12:8] < 5 && pdn_n && mclk_ok;
  endfunction

  task automatic check(input string req);
    checks++;
    if (seen() !== model()) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, seen(), model());
    end
  endtask

  task automatic load_defaults();
    for (int i = 0; i < 5; i++) m[i] = dflt(i);
  endtask

  // n = 16 normal; 15 drops the last bit; 17 appends one extra bit
  task automatic send(input logic [15:0] f, input int n, input string req, input bit mid_check);
    logic [16:0] bits;
    bits = (n == 17) ? {f, 1'b1} : (n == 15) ? {2'b0, f[15:1]} : {1'b0, f};
    @(negedge clk) csn_i = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = n - 1; i >= 0; i--) begin
      sdat_i = bits[i]; sclk_i = 1'b0;
      repeat (4) @(negedge clk);
      sclk_i = 1'b1;
      repeat (4) @(negedge clk);
    end
    repeat (4) @(negedge clk);
    if (mid_check) check("R2");
    csn_i = 1'b1; sclk_i = 1'b0;
    if (accepted(f, n)) m[f[12:8]] = f[7:0] & keep(int'(f[12:8]));
    repeat (6) @(negedge clk);
    check(req);
  endtask

  initial begin
    load_defaults();
    void'($urandom(32'd2718));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (3) @(negedge clk);
    check("R10");

    send(16'h635A, 16, "R1", 1);            // addr 3
    send(16'h6433, 16, "R1", 0);            // addr 4
    send(16'h61A5, 16, "R8", 1);            // addr 1 fields
    send(16'h6058, 16, "R8", 0);            // addr 0 fields
    send(16'h62FF, 16, "R8", 0);            // addr 2, only bit 2 kept
    send(16'hA3C0, 16, "R3", 0);            // chip code 10
    send(16'h43C0, 16, "R3", 0);            // write bit 0
    send(16'h6311, 15, "R4", 0);
    send(16'h6311, 17, "R4", 0);
    send(16'h6577, 16, "R5", 0);
    send(16'h7F77, 16, "R5", 0);
    send(16'h6059, 16, "R9", 0);            // timing bit set
    send(16'h6058, 16, "R9", 0);            // cleared, others kept
    @(negedge clk) mclk_ok = 1'b0;
    send(16'h6401, 16, "R7", 0);
    @(negedge clk) mclk_ok = 1'b1;
    @(negedge clk) pdn_n = 1'b0;
    load_defaults();
    repeat (3) @(negedge clk);
    check("R6");
    send(16'h6312, 16, "R6", 0);
    @(negedge clk) pdn_n = 1'b1;
    repeat (2) @(negedge clk);
    check("R6");

    for (int k = 0; k < 150; k++) begin
      logic [15:0] f;
      int n, r;
      string tag;
      r = int'($urandom_range(0, 19));
      n = (r == 0) ? 15 : (r == 1) ? 17 : 16;
      f = {2'b01, 1'b1, 5'($urandom_range(0, 6)), 8'($urandom)};
      if (r == 2) f[15:14] = 2'b11;
      if (r == 3) f[13] = 1'b0;
      @(negedge clk);
      mclk_ok = ($urandom_range(0, 9) != 0);
      if ($urandom_range(0, 14) == 0) begin
        pdn_n = 1'b0; load_defaults();
      end else pdn_n = 1'b1;
      if (!pdn_n)                  tag = "R6";
      else if (!mclk_ok)           tag = "R7";
      else if (n != 16)            tag = "R4";
      else if (f[15:13] != 3'b011) tag = "R3";
      else if (f[12:8] > 4)        tag = "R5";
      else                         tag = "R1";
      send(f, n, tag, 0);
    end
    pdn_n = 1'b1; mclk_ok = 1'b1;
    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      checks++; failures++;
      $display("FAIL watchdog actual=running expected=finished");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule